// File: doc/BRIEF.md
# Five-Channel DMA Descriptor Fetch and Arm Control

This block keeps the armed state of five DMA channels and loads each channel's setup record from ordinary memory. Software writes one control word. When the abort flag is clear, that word arms the channels whose bits are set. When the abort flag is set, it disarms and cancels the channels whose bits are set. Each setup record is eight bytes long. Channel 0 finds its record at a base address of its own. Channels 1 to 4 share a second base address, with their records packed back to back, eight bytes apart.

When a channel goes from disarmed to armed, the block queues a record fetch for it. A single fetch engine serves the queue, lowest channel number first. It reads the eight bytes one at a time, in ascending address order, with at most one read outstanding. The last byte of the record holds the mode settings, and the block decodes it into per-channel outputs: transfer size, 8-bit length mode, completion interrupt mask and priority. Moving data and handling triggers are done elsewhere.

Top module: `dma_arm_fetch`

## Requirements
- R1: After reset, `armed`, `fetched` and `memRdReq` are all 0.
- R2: A control write with bit 5 of `ctlWrData` at 0 sets `armed[n]` for every channel n whose bit n is 1. Other channels keep their state. An already armed channel that is armed again is not fetched again, and its decoded fields are kept. Without a control write, `armed` does not change.
- R3: A control write with bit 5 at 1 clears `armed[n]` and `fetched[n]` and zeroes the decoded fields of every channel n whose bit n is 1. Channels whose bit is 0 are left exactly as they were.
- R4: Channel 0's record is read from `base0Addr + k`, for k = 0 to 7.
- R5: Channel n (1 to 4) reads its record from `baseNAddr + 8*(n-1) + k`, for k = 0 to 7, with 16-bit wrap-around addition.
- R6: A read is requested by holding `memRdReq` high. Its address stays stable until a cycle in which `memRdAck` is high, and `memRdData` is taken in that same cycle. Only one read is ever outstanding.
- R7: When several channels are waiting for their record, they are fetched one after another in ascending channel order. Each record is read completely before the next one starts.
- R8: After the eighth byte is acknowledged, `fetched[n]` goes to 1. The fields come from that byte: bits 1:0 are the priority (`descPrio[2n+1:2n]`), bit 2 is the interrupt mask, bit 3 is the 8-bit length mode and bit 4 is the word size (1 = 16-bit). `fetched` is never 1 for a channel that is not armed.
- R9: `descLen8[n]` is 1 only when the record selects 8-bit length mode and byte transfers. For word transfers it reads 0.
- R10: Aborting the channel whose record is being fetched drops the partial fetch. `memRdReq` is low in the cycle after the write. The engine returns to idle, and a later arm fetches the record again from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| base0Addr | input | 16 | Record address for channel 0 |
| baseNAddr | input | 16 | Start of the packed records for channels 1 to 4 |
| ctlWrEn | input | 1 | Control write strobe |
| ctlWrData | input | 6 | Bits 4:0 channel mask, bit 5 abort flag |
| memRdReq | output | 1 | Memory read request |
| memRdAddr | output | 16 | Memory read byte address |
| memRdAck | input | 1 | Read acknowledge; data valid in this cycle |
| memRdData | input | 8 | Read data byte |
| armed | output | 5 | Per-channel armed state |
| fetched | output | 5 | Per-channel record loaded and decoded |
| descWord | output | 5 | Per-channel word (16-bit) transfer size |
| descLen8 | output | 5 | Per-channel effective 8-bit length mode |
| descIrqMask | output | 5 | Per-channel completion interrupt mask |
| descPrio | output | 10 | Per-channel 2-bit priority, channel n at bits 2n+1:2n |

## Verification
The assertions check the control-word rules on every cycle. An arm write ORs its mask into `armed`. An abort write clears exactly the masked channels and spares the rest. `armed` never changes without a write. They also check that a pending read keeps its address until it is acknowledged, that no unarmed channel reports a loaded record, and that the length mode never shows alongside word size. The bench scenarios cover the rest, because each needs a view of a whole sequence:

- the exact address sequence of each record, including the carry across a 256-byte boundary
- the ascending-channel order when several channels are armed at once
- the decoding of the eighth byte
- re-arming an already armed channel without a refetch
- dropping a fetch that is aborted mid-way and restarting it later

// File: rtl/dma_arm_pkg.sv
package dma_arm_pkg;
  localparam int CH_COUNT   = 5;
  localparam int DESC_BYTES = 8;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int PRIO_W     = 2;
  localparam int CHAN_W     = $clog2(CH_COUNT);
  localparam int IDX_W      = $clog2(DESC_BYTES);
  localparam int CTL_W      = CH_COUNT + 1;
  // Field positions inside the last byte of a record
  localparam int PRIO_LSB   = 0;
  localparam int IRQ_BIT    = 2;
  localparam int LEN8_BIT   = 3;
  localparam int WORD_BIT   = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic              capture;   // last byte accepted for chan
    logic [CHAN_W-1:0] chan;      // channel being fetched
    logic [IDX_W-1:0]  byteIdx;   // byte within the record
    logic [CH_COUNT-1:0] clrMask; // channels whose record is invalidated
  } dp_strobe_t;
endpackage

// File: rtl/dma_arm_ctrl.sv
module dma_arm_ctrl
  import dma_arm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctlWrEn,
  input  logic [CTL_W-1:0]    ctlWrData,
  input  logic                memRdAck,
  output logic [CH_COUNT-1:0] armed,
  output logic                memRdReq,
  output dp_strobe_t          stb
);
  logic [CH_COUNT-1:0] pending, wrMask, abortHit, armSet, livePending, doneMask;
  logic                wrAbort, busy, curAborted, lastByte, done;
  logic [CHAN_W-1:0]   curChan, nextChan;
  logic [IDX_W-1:0]    byteIdx;

  assign wrMask   = ctlWrData[CH_COUNT-1:0];
  assign wrAbort  = ctlWrData[CH_COUNT];
  assign abortHit = (ctlWrEn && wrAbort)  ? wrMask : '0;
  assign armSet   = (ctlWrEn && !wrAbort) ? (wrMask & ~armed) : '0;

  assign livePending = pending & ~abortHit;
  assign curAborted  = busy && abortHit[curChan];
  assign lastByte    = (byteIdx == IDX_W'(DESC_BYTES - 1));
  assign done        = busy && memRdAck && lastByte && !curAborted;
  assign doneMask    = done ? (CH_COUNT'(1) << curChan) : '0;

  // Lowest-numbered waiting channel wins
  always_comb begin
    nextChan = '0;
    for (int i = CH_COUNT - 1; i >= 0; i--)
      if (livePending[i]) nextChan = CHAN_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= '0;
      pending <= '0;
      busy    <= 1'b0;
      curChan <= '0;
      byteIdx <= '0;
    end else begin
      armed   <= (armed | armSet) & ~abortHit;
      pending <= (livePending & ~doneMask) | armSet;
      if (busy) begin
        if (curAborted || done) busy    <= 1'b0;
        else if (memRdAck)      byteIdx <= byteIdx + 1'b1;
      end else if (|livePending) begin
        busy    <= 1'b1;
        curChan <= nextChan;
        byteIdx <= '0;
      end
    end
  end

  assign memRdReq    = busy;
  assign stb.capture = done;
  assign stb.chan    = curChan;
  assign stb.byteIdx = byteIdx;
  assign stb.clrMask = abortHit | armSet;
endmodule

// File: rtl/dma_desc_dp.sv
module dma_desc_dp
  import dma_arm_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          base0Addr,
  input  logic [ADDR_W-1:0]          baseNAddr,
  input  logic [DATA_W-1:0]          memRdData,
  input  dp_strobe_t                 stb,
  output logic [ADDR_W-1:0]          memRdAddr,
  output logic [CH_COUNT-1:0]        fetched,
  output logic [CH_COUNT-1:0]        descWord,
  output logic [CH_COUNT-1:0]        descLen8,
  output logic [CH_COUNT-1:0]        descIrqMask,
  output logic [CH_COUNT*PRIO_W-1:0] descPrio
);
  logic [ADDR_W-1:0] descBase;
  logic              unusedHiBits;

  // Channel 0 has its own base; the others are packed from the shared one
  always_comb begin
    if (stb.chan == '0) descBase = base0Addr;
    else descBase = baseNAddr + ((ADDR_W'(stb.chan) - ADDR_W'(1)) << IDX_W);
  end
  assign memRdAddr    = descBase + ADDR_W'(stb.byteIdx);
  assign unusedHiBits = ^memRdData[DATA_W-1:WORD_BIT+1];

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_chan
    logic [WORD_BIT:0] modeBits;
    logic              valid;

    always_ff @(posedge clk) begin
      if (!rstN || stb.clrMask[c]) begin
        valid    <= 1'b0;
        modeBits <= '0;
      end else if (stb.capture && stb.chan == CHAN_W'(c)) begin
        valid    <= 1'b1;
        modeBits <= memRdData[WORD_BIT:0];
      end
    end

    assign fetched[c]     = valid;
    assign descWord[c]    = modeBits[WORD_BIT];
    assign descLen8[c]    = modeBits[LEN8_BIT] & ~modeBits[WORD_BIT];
    assign descIrqMask[c] = modeBits[IRQ_BIT];
    assign descPrio[c*PRIO_W +: PRIO_W] = modeBits[PRIO_LSB +: PRIO_W];
  end
endmodule

// File: rtl/dma_arm_fetch.sv
module dma_arm_fetch
  import dma_arm_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          base0Addr,
  input  logic [ADDR_W-1:0]          baseNAddr,
  input  logic                       ctlWrEn,
  input  logic [CTL_W-1:0]           ctlWrData,
  output logic                       memRdReq,
  output logic [ADDR_W-1:0]          memRdAddr,
  input  logic                       memRdAck,
  input  logic [DATA_W-1:0]          memRdData,
  output logic [CH_COUNT-1:0]        armed,
  output logic [CH_COUNT-1:0]        fetched,
  output logic [CH_COUNT-1:0]        descWord,
  output logic [CH_COUNT-1:0]        descLen8,
  output logic [CH_COUNT-1:0]        descIrqMask,
  output logic [CH_COUNT*PRIO_W-1:0] descPrio
);
  dp_strobe_t stb;

  dma_arm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .memRdAck(memRdAck), .armed(armed), .memRdReq(memRdReq), .stb(stb)
  );

  dma_desc_dp u_dp (
    .clk(clk), .rstN(rstN), .base0Addr(base0Addr), .baseNAddr(baseNAddr),
    .memRdData(memRdData), .stb(stb), .memRdAddr(memRdAddr),
    .fetched(fetched), .descWord(descWord), .descLen8(descLen8),
    .descIrqMask(descIrqMask), .descPrio(descPrio)
  );
endmodule

// File: rtl/dma_arm_fetch_chk.sv
module dma_arm_fetch_chk
  import dma_arm_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                ctlWrEn,
  input logic [CTL_W-1:0]    ctlWrData,
  input logic                memRdReq,
  input logic [ADDR_W-1:0]   memRdAddr,
  input logic                memRdAck,
  input logic [CH_COUNT-1:0] armed,
  input logic [CH_COUNT-1:0] fetched,
  input logic [CH_COUNT-1:0] descWord,
  input logic [CH_COUNT-1:0] descLen8
);
  p_arm_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && !ctlWrData[CH_COUNT]) |=>
      armed == ($past(armed) | $past(ctlWrData[CH_COUNT-1:0])));

  p_armed_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWrEn |=> armed == $past(armed));

  p_abort_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlWrData[CH_COUNT]) |=>
      (armed & $past(ctlWrData[CH_COUNT-1:0])) == '0);

  p_abort_spares_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlWrData[CH_COUNT]) |=>
      (armed & ~$past(ctlWrData[CH_COUNT-1:0])) ==
      ($past(armed) & ~$past(ctlWrData[CH_COUNT-1:0])));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdAck && !ctlWrEn) |=> memRdReq && $stable(memRdAddr));

  p_fetched_armed_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fetched & ~armed) == '0);

  p_len8_byte_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    (descLen8 & descWord) == '0);
endmodule

bind dma_arm_fetch dma_arm_fetch_chk u_chk (.*);

// File: tb/test_dma_arm_fetch.sv
`timescale 1ns/1ps
module test_dma_arm_fetch;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] base0Addr, baseNAddr;
  logic        ctlWrEn;
  logic [5:0]  ctlWrData;
  logic        memRdReq;
  logic [15:0] memRdAddr;
  logic        memRdAck;
  logic [7:0]  memRdData;
  logic [4:0]  armed, fetched, descWord, descLen8, descIrqMask;
  logic [9:0]  descPrio;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // memory model state
  bit          memStall = 0;
  logic [7:0]  byte7Val = 8'h00;
  logic [15:0] logAddr [0:63];
  int          logCnt = 0;
  int          waitCnt = 0;
  int          waitPat = 0;

  always #10 clk = ~clk;

  dma_arm_fetch i_dma_arm_fetch (
    .clk(clk), .rstN(rstN), .base0Addr(base0Addr), .baseNAddr(baseNAddr),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .memRdAck(memRdAck), .memRdData(memRdData),
    .armed(armed), .fetched(fetched), .descWord(descWord), .descLen8(descLen8),
    .descIrqMask(descIrqMask), .descPrio(descPrio)
  );

  // Byte memory with a rotating wait of 0..2 cycles; byte 7 of a record returns byte7Val
  always @(negedge clk) begin
    if (memRdAck) memRdAck = 1'b0;
    else if (rstN && memRdReq && !memStall) begin
      if (waitCnt == 0) begin
        memRdAck  = 1'b1;
        memRdData = (memRdAddr[2:0] == 3'd7) ? byte7Val : memRdAddr[7:0];
        if (logCnt < 64) logAddr[logCnt] = memRdAddr;
        logCnt++;
        waitPat = (waitPat == 2) ? 0 : waitPat + 1;
        waitCnt = waitPat;
      end else waitCnt--;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ctlWrite(input logic [5:0] val);
    ctlWrEn = 1'b1; ctlWrData = val;
    @(negedge clk);
    ctlWrEn = 1'b0; ctlWrData = '0;
  endtask

  task automatic waitIdle(input logic [4:0] expFetched);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!memRdReq && fetched == expFetched) break;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(armed == 0,    "R1 armed",    armed, 0);
    chk(fetched == 0,  "R1 fetched",  fetched, 0);
    chk(memRdReq == 0, "R1 memRdReq", memRdReq, 0);
  endtask

  task automatic t_ch0;
    byte7Val = 8'h0E;  // prio 2, irq mask 1, len8 1, byte size
    logCnt = 0;
    ctlWrite(6'b000001);
    chk(armed == 5'b00001, "R2 arm ch0", armed, 5'b00001);
    waitIdle(5'b00001);
    chk(logCnt == 8, "R4 read count", logCnt, 8);
    for (int k = 0; k < 8; k++)
      chk(logAddr[k] == base0Addr + 16'(k), "R4 ch0 address", logAddr[k], base0Addr + 16'(k));
    chk(fetched == 5'b00001, "R8 fetched", fetched, 5'b00001);
    chk(descPrio[1:0] == 2'd2, "R8 prio", descPrio[1:0], 2);
    chk(descIrqMask[0] == 1'b1, "R8 irq mask", descIrqMask[0], 1);
    chk(descWord[0] == 1'b0, "R8 word size", descWord[0], 0);
    chk(descLen8[0] == 1'b1, "R9 len8 on byte size", descLen8[0], 1);
  endtask

  task automatic t_order;
    int chans [3] = '{1, 3, 4};
    byte7Val = 8'h19;  // prio 1, irq 0, len8 1, word size
    logCnt = 0;
    ctlWrite(6'b011010);
    chk(armed == 5'b11011, "R2 arm adds", armed, 5'b11011);
    waitIdle(5'b11011);
    chk(logCnt == 24, "R7 read count", logCnt, 24);
    for (int j = 0; j < 3; j++)
      for (int k = 0; k < 8; k++) begin
        logic [15:0] e;
        e = baseNAddr + 16'(8 * (chans[j] - 1) + k);
        chk(logAddr[8*j+k] == e, "R5/R7 packed address order", logAddr[8*j+k], e);
      end
    chk(descWord[3] == 1'b1, "R8 word ch3", descWord[3], 1);
    chk(descPrio[7:6] == 2'd1, "R8 prio ch3", descPrio[7:6], 1);
    chk(descLen8[3] == 1'b0, "R9 len8 masked by word", descLen8[3], 0);
    chk(descPrio[1:0] == 2'd2, "R2 ch0 fields kept", descPrio[1:0], 2);
  endtask

  task automatic t_rearm;
    logCnt = 0;
    ctlWrite(6'b000010);
    repeat (10) @(negedge clk);
    chk(logCnt == 0, "R2 no refetch", logCnt, 0);
    chk(armed == 5'b11011, "R2 rearm armed", armed, 5'b11011);
    chk(fetched == 5'b11011, "R2 rearm fetched", fetched, 5'b11011);
    chk(descWord[1] == 1'b1, "R2 rearm fields kept", descWord[1], 1);
  endtask

  task automatic t_abort;
    ctlWrite(6'b101000);
    chk(armed == 5'b10011, "R3 abort armed", armed, 5'b10011);
    chk(fetched == 5'b10011, "R3 abort fetched", fetched, 5'b10011);
    chk(descWord[3] == 1'b0, "R3 fields zeroed", descWord[3], 0);
    chk(descPrio[7:6] == 2'd0, "R3 prio zeroed", descPrio[7:6], 0);
    chk(descWord[4] == 1'b1, "R3 others kept", descWord[4], 1);
    repeat (5) @(negedge clk);
    chk(memRdReq == 1'b0, "R3 no fetch after abort", memRdReq, 0);
  endtask

  task automatic t_abort_mid;
    logic [15:0] a1;
    memStall = 1;
    logCnt = 0;
    ctlWrite(6'b000100);
    repeat (3) @(negedge clk);
    chk(memRdReq == 1'b1, "R6 request raised", memRdReq, 1);
    chk(memRdAddr == baseNAddr + 16'd8, "R5 ch2 first address", memRdAddr, baseNAddr + 16'd8);
    a1 = memRdAddr;
    @(negedge clk);
    chk(memRdAddr == a1 && memRdReq, "R6 address held", memRdAddr, a1);
    ctlWrite(6'b100100);
    chk(memRdReq == 1'b0, "R10 request dropped", memRdReq, 0);
    chk(armed == 5'b10011, "R10 armed", armed, 5'b10011);
    chk(fetched == 5'b10011, "R10 fetched", fetched, 5'b10011);
    memStall = 0;
    repeat (10) @(negedge clk);
    chk(logCnt == 0, "R10 no reads after abort", logCnt, 0);
    byte7Val = 8'h07;  // prio 3, irq 1, byte size
    ctlWrite(6'b000100);
    waitIdle(5'b10111);
    chk(fetched == 5'b10111, "R10 refetch done", fetched, 5'b10111);
    chk(logAddr[0] == baseNAddr + 16'd8, "R10 restart at byte 0", logAddr[0], baseNAddr + 16'd8);
    chk(descPrio[5:4] == 2'd3, "R10 refetched prio", descPrio[5:4], 3);
    chk(descIrqMask[2] == 1'b1, "R10 refetched irq", descIrqMask[2], 1);
  endtask

  initial begin
    rstN = 1'b0; ctlWrEn = 1'b0; ctlWrData = '0;
    memRdAck = 1'b0; memRdData = '0;
    base0Addr = 16'h1230; baseNAddr = 16'h4AF8;
    @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_ch0();
    t_order();
    t_rearm();
    t_abort();
    t_abort_mid();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule